// File: doc/BRIEF.md
# Serial Gain-Word Loader with Transmit Gating

This block sits between a slow three-wire control port and the gain path of a line driver. A host lowers the active-low load-enable line and clocks a gain word in, most significant bit first, one bit per rising edge of the serial clock. When load-enable rises again, the word is committed to a parallel gain latch that drives the attenuator. Shifting is then blocked until the next load window opens.

The committed code is decoded into a coarse step index, which is the position of the highest set bit. Each step corresponds to roughly 6 dB of gain. Any code with its top bit set selects the maximum step. Code zero raises an isolation (mute) flag.

Forward transmission is gated in two ways. An asynchronous power-up input acts on the transmit enable without waiting for a clock. In addition, transmission stays off after reset until the first word has been committed. All sequential logic runs on a fast system clock, and the three serial lines are synchronized into that clock domain before their edges are detected.

Top module: `gain_word_loader`

## Requirements
- R1: While the synchronized load-enable is low, each rising edge of the synchronized serial clock shifts the synchronized data bit into bit 0 of the shift register, and the earlier bits move one place toward bit 7. Bit 7 is therefore the first bit sent (MSB first).
- R2: While load-enable is high, serial clock edges do not change the shift register.
- R3: `gain_code_o` keeps its previous value throughout a load window, until load-enable rises.
- R4: A rising edge of the synchronized load-enable copies the shift register into the gain latch. The new value appears at `gain_code_o` no more than 4 system clocks after the pin rises.
- R5: `step_idx_o` equals the index of the highest set bit of `gain_code_o`, so code 1 gives 0 and code 64 gives 6. Every code from 128 to 255 gives 7.
- R6: `mute_o` is 1 exactly when `gain_code_o` is zero. In that case `step_idx_o` is 0.
- R7: `tx_en_o` is `pwr_up_i` AND "a word has been committed since reset". The path from `pwr_up_i` has no register, so a 0 on `pwr_up_i` turns the enable off at once.
- R8: While `rst_n` is low, and after reset until the first commit, the outputs are: shift register and latch cleared, `gain_code_o` = 0, `mute_o` = 1, `step_idx_o` = 0, and `tx_en_o` = 0 even with `pwr_up_i` high.
- R9: If more than 8 serial clock edges arrive in one window, only the last 8 bits are kept. If fewer arrive, the register is committed as it stands, including bits left over from earlier windows.
- R10: Intermediate codes, meaning codes with more than one bit set, are latched without change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial clock, asynchronous and slow |
| ser_dat_i | input | 1 | Serial data, MSB first |
| ser_load_n_i | input | 1 | Active-low load enable; a rising edge commits the word |
| pwr_up_i | input | 1 | 1 = forward transmission allowed, 0 = powered down (asynchronous) |
| gain_code_o | output | WORD_W | Committed gain code |
| step_idx_o | output | $clog2(WORD_W) | Coarse step index |
| mute_o | output | 1 | Isolation state (code zero) |
| tx_en_o | output | 1 | Forward transmit enable |

## Verification
The shift register cannot be seen at the ports. A fault in it shows up only at the next commit, as a wrong `gain_code_o` and a wrong `step_idx_o`, within 4 clocks of load-enable rising. For this reason the bench commits empty windows and short windows, so that the contents left in the register are exposed. A fault in the commit-edge detector shows up either as a code change in the middle of a window or as a missing update after load-enable rises. A fault in the committed-flag or power gating shows up immediately on `tx_en_o`, without any clock, when `pwr_up_i` toggles or reset is released.

// File: rtl/gain_word_loader.sv
module gain_word_loader #(
  parameter int WORD_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W      = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk_i,
  input  logic              ser_dat_i,
  input  logic              ser_load_n_i,
  input  logic              pwr_up_i,
  output logic [WORD_W-1:0] gain_code_o,
  output logic [IDX_W-1:0]  step_idx_o,
  output logic              mute_o,
  output logic              tx_en_o
);

  logic [SYNC_STAGES-1:0] sck_sync, dat_sync, len_sync;
  logic sck_d, len_d;
  logic [WORD_W-1:0] shreg_q, latch_q;
  logic armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sync <= '0;
      dat_sync <= '0;
      len_sync <= '1;
      sck_d    <= 1'b0;
      len_d    <= 1'b1;
    end else begin
      sck_sync <= {sck_sync[SYNC_STAGES-2:0], ser_clk_i};
      dat_sync <= {dat_sync[SYNC_STAGES-2:0], ser_dat_i};
      len_sync <= {len_sync[SYNC_STAGES-2:0], ser_load_n_i};
      sck_d    <= sck_sync[SYNC_STAGES-1];
      len_d    <= len_sync[SYNC_STAGES-1];
    end
  end

  wire sck_s  = sck_sync[SYNC_STAGES-1];
  wire dat_s  = dat_sync[SYNC_STAGES-1];
  wire len_s  = len_sync[SYNC_STAGES-1];
  wire shift  = sck_s & ~sck_d & ~len_s;
  wire commit = len_s & ~len_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     shreg_q <= '0;
    else if (shift) shreg_q <= {shreg_q[WORD_W-2:0], dat_s};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      armed_q <= 1'b0;
    end else if (commit) begin
      latch_q <= shreg_q;
      armed_q <= 1'b1;
    end
  end

  always_comb begin
    step_idx_o = '0;
    for (int i = 0; i < WORD_W; i++)
      if (latch_q[i]) step_idx_o = IDX_W'(i);
  end

  assign gain_code_o = latch_q;
  assign mute_o      = (latch_q == '0);
  assign tx_en_o     = pwr_up_i & armed_q;

  a_r1_shift_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
    shift |=> (shreg_q[0] == $past(dat_s)) && (shreg_q[WORD_W-1:1] == $past(shreg_q[WORD_W-2:0])));
  a_r2_no_shift_high: assert property (@(posedge clk) disable iff (!rst_n)
    len_s |=> $stable(shreg_q));
  a_r3_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !len_s |=> $stable(latch_q));
  a_r4_commit_copies: assert property (@(posedge clk) disable iff (!rst_n)
    (len_s && !len_d) |=> (latch_q == $past(shreg_q)) && armed_q);
  a_r5_top_bit_max: assert property (@(posedge clk) disable iff (!rst_n)
    gain_code_o[WORD_W-1] |-> (step_idx_o == IDX_W'(WORD_W-1)));
  a_r6_mute_step_zero: assert property (@(posedge clk) disable iff (!rst_n)
    mute_o |-> (step_idx_o == '0) && !gain_code_o[0]);
  a_r7_pd_blocks_tx: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_up_i |-> !tx_en_o);
  a_r8_tx_needs_commit: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en_o |-> armed_q);

endmodule

// File: tb/test_gain_word_loader.sv
module test_gain_word_loader;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, sdat = 1'b0, sload_n = 1'b1, pwr = 1'b1;
  logic [7:0] code;
  logic [2:0] step;
  logic mute, txen;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gain_word_loader i_gain_word_loader (
    .clk(clk), .rst_n(rst_n), .ser_clk_i(sck), .ser_dat_i(sdat),
    .ser_load_n_i(sload_n), .pwr_up_i(pwr), .gain_code_o(code),
    .step_idx_o(step), .mute_o(mute), .tx_en_o(txen));

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_bit(input logic b);
    sdat = b; wclk(3);
    sck = 1'b1; wclk(3);
    sck = 1'b0; wclk(3);
  endtask

  task automatic send(input logic [15:0] bits, input int n);
    sload_n = 1'b0; wclk(4);
    for (int i = n - 1; i >= 0; i--) pulse_bit(bits[i]);
    sload_n = 1'b1; wclk(6);
  endtask

  task automatic t_reset;
    chk("R8 code", code, 0); chk("R8 mute", mute, 1);
    chk("R8 step", step, 0); chk("R8 tx_en in reset", txen, 0);
    rst_n = 1'b1; wclk(5);
    chk("R8 tx_en before commit", txen, 0);
  endtask

  task automatic t_nominal;
    for (int k = 0; k < 8; k++) begin
      send(16'(1 << k), 8);
      chk("R1 R4 code", code, 1 << k);
      chk("R5 step", step, k);
      chk("R6 mute", mute, 0);
    end
    chk("R7 tx_en after commit", txen, 1);
  endtask

  task automatic t_intermediate;
    send(16'h00C3, 8);
    chk("R10 code C3", code, 8'hC3); chk("R5 top bit max", step, 7);
    send(16'h002D, 8);
    chk("R10 code 2D", code, 8'h2D); chk("R5 step 2D", step, 5);
  endtask

  task automatic t_hold;
    sload_n = 1'b0; wclk(4);
    pulse_bit(1'b0); pulse_bit(1'b1); pulse_bit(1'b1);
    chk("R3 code held in window", code, 8'h2D);
    for (int i = 0; i < 5; i++) pulse_bit(1'b0);
    chk("R3 code held before commit", code, 8'h2D);
    sload_n = 1'b1; wclk(4);
    chk("R4 commit within 4 clocks", code, 8'h60);
  endtask

  task automatic t_long_short;
    send(16'hF05A, 12);
    chk("R9 last eight kept", code, 8'h5A);
    send(16'h0005, 3);
    chk("R9 short window", code, 8'hD5);
  endtask

  task automatic t_ignored;
    send(16'h0011, 8);
    for (int i = 0; i < 4; i++) pulse_bit(1'b1);
    chk("R2 code unchanged", code, 8'h11);
    send(16'h0000, 0);
    chk("R2 register untouched", code, 8'h11);
  endtask

  task automatic t_zero;
    send(16'h0000, 8);
    chk("R6 mute on zero", mute, 1); chk("R6 step zero", step, 0);
    chk("R7 tx_en at zero code", txen, 1);
  endtask

  task automatic t_power;
    send(16'h0040, 8);
    @(posedge clk); #2 pwr = 1'b0; #1;
    chk("R7 immediate off", txen, 0);
    wclk(3);
    chk("R7 code kept", code, 8'h40);
    pwr = 1'b1; #1;
    chk("R7 back on", txen, 1);
    rst_n = 1'b0; #1;
    chk("R8 reset clears tx_en", txen, 0);
    chk("R8 reset clears code", code, 0);
    wclk(2); rst_n = 1'b1; wclk(4);
    chk("R8 off until commit", txen, 0);
  endtask

  initial begin
    wclk(3);
    t_reset(); t_nominal(); t_intermediate(); t_hold();
    t_long_short(); t_ignored(); t_zero(); t_power();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule